// File: doc/BRIEF.md
# Configurable 16-bit Base Timer

This block is the free-running 16-bit time base shared by a group of capture and compare channels. A single control byte chooses where count events come from, whether the counter clears itself on reaching a compare value, and which counter bit marks an overflow. Count events come either from an internal timer clock enable, which can optionally be halved, or from a two-phase (quadrature) signal pair. That pair is synchronised inside the block and decoded for both step and direction.

A global run input acts as the timer's reset. While run is low the counter is forced to zero and the control byte may be rewritten. While run is high, writes to the control byte are dropped. When the count source changes from one non-zero choice to a different one, a guard applies. The block lets the new choice take effect only after the field has passed through the stopped setting and the previous source has delivered four events. An overflow sets a sticky request flag, which stays set until it is cleared explicitly.

Top module: `base_ctr16`

## Requirements
- R1: After reset, `ctl_rdata` reads 00h, `count` is 0000h and `irq` is 0.
- R2: The control byte is written from `ctl_wdata` only when `ctl_we` is high and `run` is low. Writes while `run` is high are ignored. The layout is: bits 1:0 = source, bit 2 = match-clear enable, bit 7 = overflow bit select. Bits 6:3 always read 0.
- R3: While `run` is low, `count` is 0000h one cycle later and no overflow is raised.
- R4: Source 00 (stopped) and source 01 (reserved) never count. Source 11 counts one per internal event, where an internal event is a `tmr_tick` pulse, or every second pulse when the latched half-rate choice is set. `tick_half_sel` is latched only while the source field reads 00.
- R5: Source 10 counts quadrature edges only when `cnt_mode` is 10. With any other mode it does not count.
- R6: A change from one non-zero source to a different non-zero source takes effect only after the previous source has produced 4 events. Until then the counter does not advance.
- R7: With bit 7 = 0, counting up (`cnt_mode` 00 or 11) from FFFFh to 0000h is an overflow. No earlier up step is an overflow.
- R8: With bit 7 = 0, counting down (`cnt_mode` 01) from 8000h to 7FFFh is an overflow. The step 0000h to FFFFh is not.
- R9: With bit 7 = 1, an overflow is a 1-to-0 step of count bit 14. Examples are 7FFFh to 8000h going up, and C000h to BFFFh going down.
- R10: `irq` rises the cycle after an overflow and stays at 1 until `irq_clr` is sampled high. A reset of the timer through `run` does not clear it.
- R11: With bit 2 = 1 and `run` high, a counter equal to `cmp_val` becomes 0000h on the next edge. This clear takes priority over the count step, and the clear is never an overflow. With bit 2 = 0, a match has no effect.
- R12: In quadrature mode the (a,b) sequence 00, 10, 11, 01 counts up by one per step and the reverse order counts down. A change of both inputs at once is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 = timer running, 0 = timer held at zero and control writable |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read data |
| cnt_mode | input | 2 | 00 up, 01 down, 10 quadrature, 11 up |
| tmr_tick | input | 1 | Internal timer clock enable |
| tick_half_sel | input | 1 | Requests the half-rate internal clock |
| quad_a | input | 1 | Quadrature phase A (asynchronous) |
| quad_b | input | 1 | Quadrature phase B (asynchronous) |
| cmp_val | input | 16 | Match-clear compare value |
| irq_clr | input | 1 | Clears the request flag |
| irq | output | 1 | Sticky overflow request |
| count | output | 16 | Counter value |

## Verification
A wrong source-gating or guard state appears at `count` within one event: the counter either moves when it should hold or holds when it should move. A wrong overflow detector shows on `irq` one edge after the exact boundary step, so the bench sweeps the whole counter range in both directions and compares `count` and `irq` at the cycles just before and just after each boundary. A stale guard or latched half-rate choice is only visible later, on the next source change, so those cases are checked across sequences of writes.

// File: rtl/base_ctr16.sv
module base_ctr16 #(
  parameter int GUARD_TICKS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        ctl_we,
  input  logic [7:0]  ctl_wdata,
  output logic [7:0]  ctl_rdata,
  input  logic [1:0]  cnt_mode,
  input  logic        tmr_tick,
  input  logic        tick_half_sel,
  input  logic        quad_a,
  input  logic        quad_b,
  input  logic [15:0] cmp_val,
  input  logic        irq_clr,
  output logic        irq,
  output logic [15:0] count
);
  localparam int GW = $clog2(GUARD_TICKS + 1);
  localparam logic [1:0] SRC_OFF  = 2'b00;
  localparam logic [1:0] SRC_QUAD = 2'b10;
  localparam logic [1:0] SRC_INT  = 2'b11;
  localparam logic [1:0] MODE_DN  = 2'b01;
  localparam logic [1:0] MODE_QD  = 2'b10;

  logic [1:0] src_req, prev_src, src_act;
  logic       mrst_en, ovf_sel, half_q, div_ph;
  logic [GW-1:0] guard;
  logic [SYNC_STAGES-1:0] qa_s, qb_s;
  logic       qa_p, qb_p;

  assign ctl_rdata = {ovf_sel, 4'b0000, mrst_en, src_req};

  wire ctl_wr   = ctl_we & ~run;
  wire int_tick = tmr_tick & (~half_q | div_ph);
  wire qa_now   = qa_s[SYNC_STAGES-1];
  wire qb_now   = qb_s[SYNC_STAGES-1];
  wire q_edge   = (qa_now ^ qa_p) ^ (qb_now ^ qb_p);
  wire q_up     = qa_now ^ qb_p;

  wire gate_ok = (prev_src == SRC_OFF) || (src_req == prev_src) ||
                 (guard >= GW'(GUARD_TICKS));
  assign src_act = ((src_req == SRC_INT || src_req == SRC_QUAD) && gate_ok) ? src_req : SRC_OFF;

  wire prev_tick = (prev_src == SRC_INT)  ? int_tick :
                   (prev_src == SRC_QUAD) ? q_edge : 1'b0;

  wire step = ((src_act == SRC_INT) & int_tick) |
              ((src_act == SRC_QUAD) & (cnt_mode == MODE_QD) & q_edge);
  wire down = (cnt_mode == MODE_DN) |
              ((cnt_mode == MODE_QD) & (src_act == SRC_QUAD) & ~q_up);

  wire [15:0] stepped = down ? count - 16'd1 : count + 16'd1;
  wire match = mrst_en & (count == cmp_val);
  wire old_b = ovf_sel ? count[14]   : count[15];
  wire new_b = ovf_sel ? stepped[14] : stepped[15];
  wire ovf   = run & ~match & step & old_b & ~new_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_req <= SRC_OFF;
      mrst_en <= 1'b0;
      ovf_sel <= 1'b0;
    end else if (ctl_wr) begin
      src_req <= ctl_wdata[1:0];
      mrst_en <= ctl_wdata[2];
      ovf_sel <= ctl_wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      div_ph <= 1'b0;
    end else begin
      if (src_req == SRC_OFF) half_q <= tick_half_sel;
      if (tmr_tick) div_ph <= ~div_ph;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qa_s <= '0;
      qb_s <= '0;
      qa_p <= 1'b0;
      qb_p <= 1'b0;
    end else begin
      qa_s <= {qa_s[SYNC_STAGES-2:0], quad_a};
      qb_s <= {qb_s[SYNC_STAGES-2:0], quad_b};
      qa_p <= qa_now;
      qb_p <= qb_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_src <= SRC_OFF;
      guard    <= '0;
    end else if (src_act != SRC_OFF) begin
      prev_src <= src_act;
      guard    <= '0;
    end else if (prev_tick && guard < GW'(GUARD_TICKS)) begin
      guard <= guard + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= 16'h0000;
    else if (!run)   count <= 16'h0000;
    else if (match)  count <= 16'h0000;
    else if (step)   count <= stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (ovf)     irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end
endmodule

module base_ctr16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        irq_clr,
  input logic [7:0]  ctl_rdata,
  input logic [15:0] cmp_val,
  input logic        irq,
  input logic [15:0] count
);
  AST_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count == 16'h0000); // R3

  AST_CTL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(ctl_rdata)); // R2

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq); // R10

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (count == $past(count)) || (count == 16'($past(count) + 16'd1)) ||
            (count == 16'($past(count) - 16'd1)) || (count == 16'h0000)); // R4

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    run && ctl_rdata[1:0] == 2'b00 |=> (count == $past(count)) || (count == 16'h0000)); // R4

  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    run && ctl_rdata[2] && count == cmp_val |=> count == 16'h0000); // R11
endmodule

bind base_ctr16 base_ctr16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .irq_clr(irq_clr), .ctl_rdata(ctl_rdata),
  .cmp_val(cmp_val), .irq(irq), .count(count)
);

// File: tb/tb_base_ctr16.sv
module tb_base_ctr16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic [1:0] cnt_mode = 2'b00;
  logic tmr_tick = 1'b0;
  logic tick_half_sel = 1'b0;
  logic quad_a = 1'b0;
  logic quad_b = 1'b0;
  logic [15:0] cmp_val = 16'h1234;
  logic irq_clr = 1'b0;
  logic irq;
  logic [15:0] count;

  int n_chk = 0;
  int n_bad = 0;
  int qpos = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  base_ctr16 dut (
    .clk(clk), .rst_n(rst_n), .run(run), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cnt_mode(cnt_mode), .tmr_tick(tmr_tick),
    .tick_half_sel(tick_half_sel), .quad_a(quad_a), .quad_b(quad_b),
    .cmp_val(cmp_val), .irq_clr(irq_clr), .irq(irq), .count(count)
  );

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    ctl_we = 1'b1;
    ctl_wdata = d;
    tk(1);
    ctl_we = 1'b0;
  endtask

  task automatic qset();
    case (qpos & 3)
      0: begin quad_a = 1'b0; quad_b = 1'b0; end
      1: begin quad_a = 1'b1; quad_b = 1'b0; end
      2: begin quad_a = 1'b1; quad_b = 1'b1; end
      default: begin quad_a = 1'b0; quad_b = 1'b1; end
    endcase
  endtask

  task automatic qstep(input int delta);
    qpos = qpos + delta + 4;
    qset();
    tk(4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] c0;
    tk(3);
    rst_n = 1'b1;
    tk(1);
    chk("R1 ctl", {8'h00, ctl_rdata}, 16'h0000);
    chk("R1 count", count, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    wr(8'hFF);
    chk("R2 reserved bits", {8'h00, ctl_rdata}, 16'h0087);
    wr(8'h00);

    tmr_tick = 1'b1;
    wr(8'h03);
    run = 1'b1;
    tk(10);
    chk("R4 internal count", count, 16'd10);
    wr(8'h00);
    chk("R2 write ignored", {8'h00, ctl_rdata}, 16'h0003);
    chk("R2 still counting", count, 16'd11);
    run = 1'b0;
    tk(1);
    chk("R3 held zero", count, 16'h0000);

    tick_half_sel = 1'b1;
    run = 1'b1;
    tk(8);
    chk("R4 half not latched", count, 16'd8);
    run = 1'b0;
    wr(8'h00);
    tk(1);
    wr(8'h03);
    run = 1'b1;
    tk(10);
    chk("R4 half rate", count, 16'd5);
    run = 1'b0;
    tick_half_sel = 1'b0;
    wr(8'h00);
    tk(1);

    wr(8'h01);
    run = 1'b1;
    tk(5);
    chk("R4 reserved source", count, 16'h0000);
    run = 1'b0;
    wr(8'h00);
    tk(6);

    wr(8'h02);
    run = 1'b1;
    for (int i = 0; i < 4; i++) qstep(1);
    chk("R5 quad wrong mode", count, 16'h0000);
    run = 1'b0;
    cnt_mode = 2'b10;
    tk(1);
    run = 1'b1;
    for (int i = 0; i < 8; i++) qstep(1);
    chk("R12 quad up", count, 16'd8);
    for (int i = 0; i < 3; i++) qstep(-1);
    chk("R12 quad down", count, 16'd5);
    qstep(2);
    chk("R12 double change", count, 16'd5);
    run = 1'b0;
    cnt_mode = 2'b00;
    wr(8'h00);
    wr(8'h03);
    run = 1'b1;
    tk(6);
    chk("R6 guard blocks", count, 16'h0000);
    for (int i = 0; i < 3; i++) qstep(1);
    chk("R6 three events", count, 16'h0000);
    qstep(1);
    tk(2);
    c0 = count;
    tk(5);
    chk("R6 released", count, 16'(c0 + 16'd5));
    n_chk++;
    if (c0 == 16'h0000) begin
      n_bad++;
      $display("FAIL R6 release: actual %h expected nonzero", c0);
    end
    run = 1'b0;

    cmp_val = 16'd5;
    wr(8'h07);
    run = 1'b1;
    tk(5);
    chk("R11 reach match", count, 16'd5);
    tk(1);
    chk("R11 cleared", count, 16'h0000);
    tk(3);
    chk("R11 recount", count, 16'd3);
    run = 1'b0;
    wr(8'h03);
    run = 1'b1;
    tk(6);
    chk("R11 disabled", count, 16'd6);
    run = 1'b0;
    tk(1);

    run = 1'b1;
    tk(65535);
    chk("R7 at FFFF", count, 16'hFFFF);
    chk("R7 no early irq", {15'd0, irq}, 16'h0000);
    tk(1);
    chk("R7 wrap", count, 16'h0000);
    chk("R7 irq", {15'd0, irq}, 16'h0001);
    run = 1'b0;
    tk(3);
    chk("R10 sticky", {15'd0, irq}, 16'h0001);
    irq_clr = 1'b1;
    tk(1);
    irq_clr = 1'b0;
    chk("R10 cleared", {15'd0, irq}, 16'h0000);

    cnt_mode = 2'b01;
    run = 1'b1;
    tk(1);
    chk("R8 down wrap", count, 16'hFFFF);
    chk("R8 no irq on wrap", {15'd0, irq}, 16'h0000);
    tk(32767);
    chk("R8 at 8000", count, 16'h8000);
    chk("R8 no irq yet", {15'd0, irq}, 16'h0000);
    tk(1);
    chk("R8 7FFF", count, 16'h7FFF);
    chk("R8 irq", {15'd0, irq}, 16'h0001);
    run = 1'b0;
    irq_clr = 1'b1;
    tk(1);
    irq_clr = 1'b0;

    cmp_val = 16'hC000;
    wr(8'h87);
    run = 1'b1;
    tk(16384);
    chk("R11 at C000", count, 16'hC000);
    tk(1);
    chk("R11 clear value", count, 16'h0000);
    chk("R11 clear not overflow", {15'd0, irq}, 16'h0000);
    run = 1'b0;
    wr(8'h83);
    run = 1'b1;
    tk(16384);
    chk("R9 at C000", count, 16'hC000);
    chk("R9 no irq yet", {15'd0, irq}, 16'h0000);
    tk(1);
    chk("R9 BFFF", count, 16'hBFFF);
    chk("R9 irq", {15'd0, irq}, 16'h0001);
    run = 1'b0;
    tk(1);
    chk("R3 zero after run", count, 16'h0000);
    chk("R10 kept over run", {15'd0, irq}, 16'h0001);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule